// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Segment

This block is one stretch of a boundary register that sits between a test access port controller and a group of device pins. Each pin that can both drive and receive gets three scan cells: an enable cell, a data cell and an input-observation cell. Each pin that only drives gets two: an enable cell and a data cell. The enable and data cells have a shift stage and a separate update latch. The observation cell has only a shift stage. A pin's driver is on only when its enable bit is 1, so the all-zero value of every enable cell is the safe, high-impedance state.

The TAP controller supplies one-cycle strobes for capture, shift and update. It also supplies a test-mode select and two override flags, clamp and high-impedance. In functional operation the pads follow the core's data and enable. In test mode, or while clamp is set, the pads follow the update latches. The high-impedance flag turns every driver off whatever the other inputs are. Segments can be chained: `scan_out` of one segment feeds `scan_in` of the next, toward the data-out pin.

Top module: `bsc_pin_segment`

## Requirements
- R1: The chain has 3*NUM_BIDIR+2*NUM_OUT cells. Cell 0 drives `scan_out` and `scan_in` enters the highest cell. Bidirectional pin k (pin index k) uses cell 3k for enable, 3k+1 for data and 3k+2 for input observation. Output-only pin j (pin index NUM_BIDIR+j) uses cell 3*NUM_BIDIR+2j for enable and the next cell for data.
- R2: On each clock with `dr_shift` high, every cell takes the value of the cell one index above it, and the highest cell takes `scan_in`. `scan_out` shows cell 0 without a register stage.
- R3: On a clock with `dr_capture` high, enable cells load `core_oe`, data cells load `core_out` and observation cells load `pad_in`. Capture takes precedence over a shift in the same cycle.
- R4: On a clock with `dr_update` high, each enable and data latch loads its cell's shift-stage bit. Shift and capture leave the latches unchanged, and observation cells have no latch.
- R5: While `mode_test` or `force_clamp` is high (and `force_highz` is low), `pad_out` equals the data latches and `pad_oe` equals the enable latches, with 1 meaning the driver is on. Core signals have no effect in this state.
- R6: With `mode_test`, `force_clamp` and `force_highz` all low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R7: While `force_highz` is high, every bit of `pad_oe` is 0, whatever the latches and core signals are.
- R8: While `trst_n` is low, all shift stages and latches are 0, so in test mode every pad is disabled and driving 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| dr_capture | input | 1 | Capture strobe for the data register |
| dr_shift | input | 1 | Shift strobe for the data register |
| dr_update | input | 1 | Update strobe for the data register |
| mode_test | input | 1 | Pads follow the update latches (external test) |
| force_clamp | input | 1 | Pads follow the update latches while bypassed |
| force_highz | input | 1 | All pad drivers off |
| scan_in | input | 1 | Serial input from the segment nearer the data-in pin |
| scan_out | output | 1 | Serial output toward the data-out pin |
| core_out | input | NUM_BIDIR+NUM_OUT | Functional output data from the core |
| core_oe | input | NUM_BIDIR+NUM_OUT | Functional output enable from the core, active high |
| pad_in | input | NUM_BIDIR | Receiver values of the bidirectional pads |
| pad_out | output | NUM_BIDIR+NUM_OUT | Data to the pad drivers |
| pad_oe | output | NUM_BIDIR+NUM_OUT | Pad driver enables, active high |

## Verification
The bench builds the segment with three bidirectional pins and two output-only pins, which gives a 13-cell chain. This mix places the boundary between the three-cell and two-cell layouts in the middle of the chain, so a misplaced index in either layout shows up in the serial stream. A scoreboard queues the bit expected at `scan_out` for each shift cycle from a bench-side model of the layout, so every captured and shifted-through value is checked at its cell position. Pad checks cover functional, test, clamp and high-impedance selection, simultaneous capture and shift, and a reset applied after the latches hold drive-on values.

// File: rtl/bsc_seg_pkg.sv
package bsc_seg_pkg;

   typedef enum logic [1:0] {
      CELL_ENABLE  = 2'd0,
      CELL_DATA    = 2'd1,
      CELL_OBSERVE = 2'd2
   } cell_kind_e;

   function automatic int unsigned seg_length(input int unsigned nbd, input int unsigned nout);
      return 3 * nbd + 2 * nout;
   endfunction

   // first cell of a pin: bidirectional pins take three cells, output-only two
   function automatic int unsigned pin_base(input int unsigned pin, input int unsigned nbd);
      if (pin < nbd) return 3 * pin;
      return 3 * nbd + 2 * (pin - nbd);
   endfunction

   function automatic int unsigned cell_of(input int unsigned pin, input int unsigned nbd,
                                           input cell_kind_e kind);
      return pin_base(pin, nbd) + int'(kind);
   endfunction

endpackage

// File: rtl/bsc_upd_cell.sv
module bsc_upd_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shf_en,
   input  logic upd_en,
   input  logic cap_d,
   input  logic ser_d,
   output logic sr_q,
   output logic upd_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q <= 1'b0;
      else if (cap_en) sr_q <= cap_d;
      else if (shf_en) sr_q <= ser_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      upd_q <= 1'b0;
      else if (upd_en) upd_q <= sr_q;
   end

endmodule

// File: rtl/bsc_obs_cell.sv
module bsc_obs_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_en,
   input  logic shf_en,
   input  logic cap_d,
   input  logic ser_d,
   output logic sr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q <= 1'b0;
      else if (cap_en) sr_q <= cap_d;
      else if (shf_en) sr_q <= ser_d;
   end

endmodule

// File: rtl/bsc_pad_sel.sv
module bsc_pad_sel (
   input  logic test_sel,
   input  logic highz,
   input  logic core_d,
   input  logic core_en,
   input  logic latch_d,
   input  logic latch_en,
   output logic pad_d,
   output logic pad_en
);

   always_comb begin
      pad_d  = test_sel ? latch_d : core_d;
      pad_en = highz ? 1'b0 : (test_sel ? latch_en : core_en);
   end

endmodule

// File: rtl/bsc_pin_segment.sv
module bsc_pin_segment
   import bsc_seg_pkg::*;
#(
   parameter int unsigned NUM_BIDIR = 4,
   parameter int unsigned NUM_OUT   = 2
) (
   input  logic                              tck,
   input  logic                              trst_n,
   input  logic                              dr_capture,
   input  logic                              dr_shift,
   input  logic                              dr_update,
   input  logic                              mode_test,
   input  logic                              force_clamp,
   input  logic                              force_highz,
   input  logic                              scan_in,
   output logic                              scan_out,
   input  logic [NUM_BIDIR+NUM_OUT-1:0]      core_out,
   input  logic [NUM_BIDIR+NUM_OUT-1:0]      core_oe,
   input  logic [NUM_BIDIR-1:0]              pad_in,
   output logic [NUM_BIDIR+NUM_OUT-1:0]      pad_out,
   output logic [NUM_BIDIR+NUM_OUT-1:0]      pad_oe
);

   localparam int unsigned NUM_PINS = NUM_BIDIR + NUM_OUT;
   localparam int unsigned SEG_LEN  = seg_length(NUM_BIDIR, NUM_OUT);

   if (NUM_BIDIR < 1) begin : g_bad_bidir
      $error("bsc_pin_segment: NUM_BIDIR must be at least 1");
   end
   if (SEG_LEN > 1024) begin : g_bad_len
      $error("bsc_pin_segment: chain longer than 1024 cells");
   end

   logic [SEG_LEN-1:0]  sr_bits;
   logic [SEG_LEN-1:0]  ser_next;
   logic [NUM_PINS-1:0] upd_ctl;
   logic [NUM_PINS-1:0] upd_dat;
   logic                test_sel;

   // each cell shifts from the one above it; the top cell takes scan_in
   assign ser_next = {scan_in, sr_bits[SEG_LEN-1:1]};
   assign scan_out = sr_bits[0];
   assign test_sel = mode_test | force_clamp;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int unsigned EN_IX = cell_of(p, NUM_BIDIR, CELL_ENABLE);
      localparam int unsigned DT_IX = cell_of(p, NUM_BIDIR, CELL_DATA);

      bsc_upd_cell u_en_cell (
         .clk    (tck),
         .rst_n  (trst_n),
         .cap_en (dr_capture),
         .shf_en (dr_shift),
         .upd_en (dr_update),
         .cap_d  (core_oe[p]),
         .ser_d  (ser_next[EN_IX]),
         .sr_q   (sr_bits[EN_IX]),
         .upd_q  (upd_ctl[p])
      );

      bsc_upd_cell u_dt_cell (
         .clk    (tck),
         .rst_n  (trst_n),
         .cap_en (dr_capture),
         .shf_en (dr_shift),
         .upd_en (dr_update),
         .cap_d  (core_out[p]),
         .ser_d  (ser_next[DT_IX]),
         .sr_q   (sr_bits[DT_IX]),
         .upd_q  (upd_dat[p])
      );

      if (p < NUM_BIDIR) begin : g_bidir
         localparam int unsigned OB_IX = cell_of(p, NUM_BIDIR, CELL_OBSERVE);
         bsc_obs_cell u_ob_cell (
            .clk    (tck),
            .rst_n  (trst_n),
            .cap_en (dr_capture),
            .shf_en (dr_shift),
            .cap_d  (pad_in[p]),
            .ser_d  (ser_next[OB_IX]),
            .sr_q   (sr_bits[OB_IX])
         );
      end

      bsc_pad_sel u_sel (
         .test_sel (test_sel),
         .highz    (force_highz),
         .core_d   (core_out[p]),
         .core_en  (core_oe[p]),
         .latch_d  (upd_dat[p]),
         .latch_en (upd_ctl[p]),
         .pad_d    (pad_out[p]),
         .pad_en   (pad_oe[p])
      );
   end

endmodule

// File: rtl/bsc_pin_segment_chk.sv
module bsc_pin_segment_chk
   import bsc_seg_pkg::*;
#(
   parameter int unsigned NUM_BIDIR = 4,
   parameter int unsigned NUM_OUT   = 2
) (
   input logic                                        tck,
   input logic                                        trst_n,
   input logic                                        dr_capture,
   input logic                                        dr_shift,
   input logic                                        dr_update,
   input logic                                        mode_test,
   input logic                                        force_clamp,
   input logic                                        force_highz,
   input logic                                        scan_out,
   input logic [NUM_BIDIR+NUM_OUT-1:0]                core_out,
   input logic [NUM_BIDIR+NUM_OUT-1:0]                core_oe,
   input logic [NUM_BIDIR-1:0]                        pad_in,
   input logic [NUM_BIDIR+NUM_OUT-1:0]                pad_out,
   input logic [NUM_BIDIR+NUM_OUT-1:0]                pad_oe,
   input logic [seg_length(NUM_BIDIR,NUM_OUT)-1:0]    sr_bits,
   input logic [NUM_BIDIR+NUM_OUT-1:0]                upd_ctl
);

   localparam int unsigned NUM_PINS = NUM_BIDIR + NUM_OUT;

   logic [NUM_PINS-1:0] en_stage;
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_en
      assign en_stage[p] = sr_bits[cell_of(p, NUM_BIDIR, CELL_ENABLE)];
   end

   // R2: serial path moves cell 1 to the output
   assert_shift_moves_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (dr_shift && !dr_capture) |=> (scan_out == $past(sr_bits[1])));

   for (genvar k = 0; k < NUM_BIDIR; k++) begin : g_obs
      localparam int unsigned OB = cell_of(k, NUM_BIDIR, CELL_OBSERVE);
      assert_obs_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
         dr_capture |=> (sr_bits[OB] == $past(pad_in[k])));
      assert_obs_hold_R3: assert property (@(posedge tck) disable iff (!trst_n)
         (!dr_capture && !dr_shift) |=> $stable(sr_bits[OB]));
   end

   assert_update_load_R4: assert property (@(posedge tck) disable iff (!trst_n)
      dr_update |=> (upd_ctl == $past(en_stage)));

   assert_latch_hold_R4: assert property (@(posedge tck) disable iff (!trst_n)
      !dr_update |=> $stable(upd_ctl));

   assert_test_enable_R5: assert property (@(posedge tck) disable iff (!trst_n)
      ((mode_test || force_clamp) && !force_highz) |-> (pad_oe == upd_ctl));

   assert_functional_R6: assert property (@(posedge tck) disable iff (!trst_n)
      (!mode_test && !force_clamp && !force_highz) |->
         (pad_out == core_out && pad_oe == core_oe));

   assert_highz_off_R7: assert property (@(posedge tck) disable iff (!trst_n)
      force_highz |-> (pad_oe == '0));

endmodule

bind bsc_pin_segment bsc_pin_segment_chk #(
   .NUM_BIDIR (NUM_BIDIR),
   .NUM_OUT   (NUM_OUT)
) u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .dr_capture  (dr_capture),
   .dr_shift    (dr_shift),
   .dr_update   (dr_update),
   .mode_test   (mode_test),
   .force_clamp (force_clamp),
   .force_highz (force_highz),
   .scan_out    (scan_out),
   .core_out    (core_out),
   .core_oe     (core_oe),
   .pad_in      (pad_in),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .sr_bits     (sr_bits),
   .upd_ctl     (upd_ctl)
);

// File: tb/bsc_pin_segment_tb.sv
`timescale 1ns/100ps
module bsc_pin_segment_tb;

   localparam int NB = 3;
   localparam int NO = 2;
   localparam int NP = NB + NO;
   localparam int L  = 3 * NB + 2 * NO;

   logic tck = 1'b0;
   logic trst_n, dr_capture, dr_shift, dr_update;
   logic mode_test, force_clamp, force_highz, scan_in, scan_out;
   logic [NP-1:0] core_out, core_oe, pad_out, pad_oe;
   logic [NB-1:0] pad_in;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 0;
   logic exp_q[$];
   string tag_q[$];

   always #2.5 tck = ~tck;

   bsc_pin_segment #(.NUM_BIDIR(NB), .NUM_OUT(NO)) u_dut (
      .tck(tck), .trst_n(trst_n), .dr_capture(dr_capture), .dr_shift(dr_shift),
      .dr_update(dr_update), .mode_test(mode_test), .force_clamp(force_clamp),
      .force_highz(force_highz), .scan_in(scan_in), .scan_out(scan_out),
      .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   // R1 layout model: expected capture image
   function automatic logic [L-1:0] cap_image(input logic [NP-1:0] co, input logic [NP-1:0] oe,
                                              input logic [NB-1:0] pi);
      logic [L-1:0] v = '0;
      for (int k = 0; k < NB; k++) begin
         v[3*k] = oe[k]; v[3*k+1] = co[k]; v[3*k+2] = pi[k];
      end
      for (int j = 0; j < NO; j++) begin
         v[3*NB+2*j] = oe[NB+j]; v[3*NB+2*j+1] = co[NB+j];
      end
      return v;
   endfunction

   function automatic logic [NP-1:0] img_oe(input logic [L-1:0] v);
      logic [NP-1:0] r;
      for (int k = 0; k < NB; k++) r[k] = v[3*k];
      for (int j = 0; j < NO; j++) r[NB+j] = v[3*NB+2*j];
      return r;
   endfunction

   function automatic logic [NP-1:0] img_out(input logic [L-1:0] v);
      logic [NP-1:0] r;
      for (int k = 0; k < NB; k++) r[k] = v[3*k+1];
      for (int j = 0; j < NO; j++) r[NB+j] = v[3*NB+2*j+1];
      return r;
   endfunction

   task automatic step();
      @(posedge tck); #1;
   endtask

   task automatic pulse_capture();
      dr_capture = 1'b1; step(); dr_capture = 1'b0;
   endtask

   task automatic pulse_update();
      dr_update = 1'b1; step(); dr_update = 1'b0;
   endtask

   // driver: queues the scan_out bit expected in each shift cycle
   task automatic shift_vec(input logic [L-1:0] din, input logic [L-1:0] expv, input string rq);
      for (int c = 0; c < L; c++) begin
         dr_shift = 1'b1;
         scan_in  = din[c];
         exp_q.push_back(expv[c]);
         tag_q.push_back($sformatf("%s cell %0d", rq, c));
         step();
      end
      dr_shift = 1'b0;
      scan_in  = 1'b0;
   endtask

   // monitor: pops and compares as the serial output appears
   always @(negedge tck) begin
      if (dr_shift && exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, 32'(scan_out), 32'(e));
      end
   end

   task automatic check_pads(input string rq, input logic [NP-1:0] eo, input logic [NP-1:0] ee);
      @(negedge tck);
      check({rq, " pad_out"}, 32'(pad_out), 32'(eo));
      check({rq, " pad_oe"}, 32'(pad_oe), 32'(ee));
      step();
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [L-1:0] img_a, vec_b, vec_c, img_d;
      trst_n = 1'b0; dr_capture = 0; dr_shift = 0; dr_update = 0;
      mode_test = 1'b1; force_clamp = 0; force_highz = 0; scan_in = 0;
      core_out = '1; core_oe = '1; pad_in = '1;
      repeat (3) step();
      check_pads("R8 reset state", '0, '0);
      check("R8 reset scan_out", 32'(scan_out), 32'd0);
      trst_n = 1'b1;
      step();

      // functional path
      mode_test = 1'b0;
      core_out = 5'b10110; core_oe = 5'b01101;
      check_pads("R6 functional A", 5'b10110, 5'b01101);
      core_out = 5'b01001; core_oe = 5'b11110;
      check_pads("R6 functional B", 5'b01001, 5'b11110);

      // capture then shift out, shifting a new image in
      core_out = 5'b11010; core_oe = 5'b10011; pad_in = 3'b101;
      img_a = cap_image(core_out, core_oe, pad_in);
      pulse_capture();
      vec_b = 13'b1_0110_1101_0011;
      shift_vec(vec_b, img_a, "R1 R3 capture image");
      pulse_update();
      mode_test = 1'b1;
      check_pads("R5 test mode from latches", img_out(vec_b), img_oe(vec_b));

      // second shift checks shift-through and that latches hold
      vec_c = 13'b0_1011_0110_1110;
      shift_vec(vec_c, vec_b, "R2 shift-through");
      check_pads("R4 latches hold during shift", img_out(vec_b), img_oe(vec_b));
      pulse_capture();
      check_pads("R4 latches hold after capture", img_out(vec_b), img_oe(vec_b));
      shift_vec(vec_c, cap_image(core_out, core_oe, pad_in), "R3 recapture");
      pulse_update();
      check_pads("R4 update loads new image", img_out(vec_c), img_oe(vec_c));

      // clamp: latches drive, core ignored
      mode_test = 1'b0; force_clamp = 1'b1;
      core_out = ~img_out(vec_c); core_oe = ~img_oe(vec_c);
      check_pads("R5 clamp ignores core", img_out(vec_c), img_oe(vec_c));

      // high impedance override
      force_highz = 1'b1; core_oe = '1;
      check_pads("R7 highz in clamp", img_out(vec_c), '0);
      force_clamp = 1'b0;
      check_pads("R7 highz functional", core_out, '0);
      force_highz = 1'b0;

      // capture and shift in the same cycle: capture wins
      core_out = 5'b00111; core_oe = 5'b11000; pad_in = 3'b010;
      img_d = cap_image(core_out, core_oe, pad_in);
      dr_capture = 1'b1; dr_shift = 1'b1; scan_in = 1'b1;
      step();
      dr_capture = 1'b0; dr_shift = 1'b0; scan_in = 1'b0;
      shift_vec('0, img_d, "R3 capture priority");

      // reset after drive-on latches
      mode_test = 1'b1;
      check_pads("R5 before reset", img_out(vec_c), img_oe(vec_c));
      trst_n = 1'b0;
      step();
      check_pads("R8 reset clears latches", '0, '0);
      check("R8 reset clears chain", 32'(scan_out), 32'd0);
      trst_n = 1'b1;
      step();

      check("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule